// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache With Allocate, Freeze and Bypass Modes

This block is a read-only instruction cache that sits between a processor's fetch port and a wide on-chip backing memory. Each line holds eight 32-bit instructions (256 bits). A fetch names a word address and gets back one instruction, with a valid flag and a stall flag. A hit answers in the same cycle the request is seen. A miss reads the whole line in one request over a 256-bit path, and the instruction is delivered a fixed two cycles after the request cycle. The backing memory returns data a fixed number of cycles after it is asked.

A 3-bit mode input picks the policy. Allocate mode fills lines on a miss. Freeze mode serves hits but leaves the arrays alone on a miss. Bypass mode sends every access to memory. The reset code is read as allocate. All other codes are handled as bypass.

Software can invalidate a range through two small registers. One holds the first word address. Writing the other with a word count starts an engine that clears one line's valid bit per cycle. Instruction fetches stall until that engine has finished. Capacity is a parameter, 32 KB by default (1024 lines).

Top module: `fetch_icache`

## Requirements
- R1: After reset every line is invalid, so the first fetch of any address misses; the register at byte offset 0x4 reads 0 (not busy, count 0).
- R2: In allocate or freeze policy, a fetch whose line is valid with a matching tag returns the instruction with `fetch_valid` high in the same cycle the request is presented, with no memory read.
- R3: A miss raises `mem_rd_en` for exactly one cycle, in the request cycle, with `mem_line_addr` equal to the word address shifted right by 3. The instruction is delivered 2 cycles later. It is taken from bits [32*k+31:32*k] of the returned line, where k is the low 3 bits of the word address.
- R4: Mode codes 3'b010 and 3'b000 both select allocate: a miss writes tag, data and valid for its line, so a later fetch anywhere in that line hits.
- R5: Mode code 3'b011 (freeze) serves hits, but a miss is served from memory and changes no line: a repeat fetch of the same address misses again.
- R6: Mode code 3'b100 (bypass) treats every fetch as a miss served from memory and leaves the cache contents unchanged; a line cached earlier still hits after a return to allocate.
- R7: Mode codes 3'b001, 3'b101, 3'b110 and 3'b111 behave exactly as bypass.
- R8: Register map: byte offset 0x0 is the 32-bit invalidate start word address (read/write). Byte offset 0x4 write takes the word count from bits [23:0]. Its read returns that count in bits [23:0] and the busy flag in bit 31.
- R9: A write to 0x4 with a non-zero count clears the valid bit of every line that covers words start to start+count-1, taken modulo the capacity and capped at all lines. With n lines, busy reads 1 for n+1 cycles starting the cycle after the write. Fetches stall while busy. A zero count does nothing, and lines outside the range stay valid.
- R10: A write to 0x4 while busy is ignored; the count readback and the range being cleared are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Cache policy code |
| fetch_req | input | 1 | Fetch request, held until served |
| fetch_addr | input | 20 | Fetch word address, held while stalled |
| fetch_valid | output | 1 | Instruction on fetch_data is valid this cycle |
| fetch_stall | output | 1 | Request present but not served this cycle |
| fetch_data | output | 32 | Instruction word |
| mem_rd_en | output | 1 | Line read request to backing memory |
| mem_line_addr | output | 17 | Line address of the read |
| mem_rd_data | input | 256 | Line returned by memory after its fixed latency |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| inv_busy | output | 1 | Invalidation pending or running |

## Verification
The bench checks the two policies that are easy to mix up. Freeze must not allocate, which is visible as a repeated miss. Bypass must not disturb stored lines, which is visible as a hit after the return to allocate. It checks that the reset code 000 allocates while the other unlisted codes fall to bypass; a design that decoded 000 as bypass would miss forever. The invalidation range is checked where its ends share lines, with the line just outside the range still hitting, and with a zero count, an oversize range and a write that lands while busy. An off-by-one in the line count shows up as a wrong busy length or a stale hit. Tag-conflict evictions and random mode switches check the latency of every fetch, 0 or 2 cycles, against a bench model of tags and valid bits.

// File: rtl/icache_pkg.sv
// Shared types for the instruction cache.
// Assumes mode codes arrive as a raw 3-bit field from the processor.
package icache_pkg;

    typedef enum logic [1:0] {
        POL_ALLOC  = 2'd0,
        POL_FREEZE = 2'd1,
        POL_BYPASS = 2'd2
    } policy_e;

    // Map the 3-bit mode code to a policy; unlisted codes fall to bypass.
    function automatic policy_e decode_mode(input logic [2:0] code);
        case (code)
            3'b000, 3'b010: return POL_ALLOC;
            3'b011:         return POL_FREEZE;
            default:        return POL_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/icache_store.sv
// Tag, data and valid arrays of the direct-mapped cache.
// Read is combinational on rd_idx. One fill write and one valid clear
// per cycle; the controller never issues both in the same cycle.
// Only valid bits are reset; tags and data need no reset.
module icache_store #(
    parameter int NUM_LINES = 1024,
    parameter int IDX_W     = 10,
    parameter int TAG_W     = 7,
    parameter int LINE_BITS = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 rd_valid,
    output logic [TAG_W-1:0]     rd_tag,
    output logic [LINE_BITS-1:0] rd_line,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [TAG_W-1:0]     wr_tag,
    input  logic [LINE_BITS-1:0] wr_line,
    input  logic                 clr_en,
    input  logic [IDX_W-1:0]     clr_idx
);

    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_mem  [NUM_LINES];
    logic [LINE_BITS-1:0] data_mem [NUM_LINES];

    // Valid bits: cleared on reset, set by a fill, cleared by invalidation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (wr_en)  valid_q[wr_idx]  <= 1'b1;
            if (clr_en) valid_q[clr_idx] <= 1'b0;
        end
    end

    // Tag and data arrays: written only by a completing allocate fill.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_line;
        end
    end

    // Combinational lookup for the current fetch index.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_mem[rd_idx];
        rd_line  = data_mem[rd_idx];
    end

endmodule

// File: rtl/icache_inv_engine.sv
// Range invalidation registers and engine.
// Offset 0x0: start word address. Offset 0x4: word count in [COUNT_W-1:0],
// busy in bit 31 on read. A count write while idle computes the number of
// covered lines, waits for the fetch controller to be idle (allow), then
// clears one line per cycle. Writes to 0x4 while busy are dropped.
// Assumes COUNT_W <= 31.
module icache_inv_engine #(
    parameter int NUM_LINES = 1024,
    parameter int IDX_W     = 10,
    parameter int OFF_W     = 3,
    parameter int COUNT_W   = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             allow,
    output logic             busy,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx
);

    localparam logic [2:0] OFS_START = 3'h0;
    localparam logic [2:0] OFS_CTRL  = 3'h4;

    logic [31:0]        start_q;
    logic [COUNT_W-1:0] count_q;
    logic               pend_q;
    logic               run_q;
    logic [IDX_W-1:0]   cur_q;
    logic [IDX_W:0]     left_q;

    logic [COUNT_W-1:0] wr_cnt;
    logic [32:0]        last_word;
    logic [32:0]        span;
    logic [IDX_W:0]     nlines;
    logic               ctrl_wr;

    // Number of lines covered by [start, start+count-1], capped at capacity.
    always_comb begin
        wr_cnt    = cfg_wdata[COUNT_W-1:0];
        last_word = {1'b0, start_q} + 33'(wr_cnt) - 33'd1;
        span      = (last_word >> OFF_W) - ({1'b0, start_q} >> OFF_W) + 33'd1;
        nlines    = (span > 33'(NUM_LINES)) ? (IDX_W+1)'(NUM_LINES)
                                            : (IDX_W+1)'(span);
        ctrl_wr   = cfg_we && (cfg_addr == OFS_CTRL) && !busy;
    end

    // Register writes, engine launch and one-line-per-cycle sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            count_q <= '0;
            pend_q  <= 1'b0;
            run_q   <= 1'b0;
            cur_q   <= '0;
            left_q  <= '0;
        end else begin
            if (cfg_we && cfg_addr == OFS_START) start_q <= cfg_wdata;
            if (ctrl_wr) begin
                count_q <= wr_cnt;
                if (wr_cnt != '0) begin
                    pend_q <= 1'b1;
                    left_q <= nlines;
                    cur_q  <= start_q[OFF_W +: IDX_W];
                end
            end
            if (pend_q && allow) begin
                pend_q <= 1'b0;
                run_q  <= 1'b1;
            end
            if (run_q) begin
                cur_q  <= cur_q + 1'b1;
                left_q <= left_q - 1'b1;
                if (left_q == (IDX_W+1)'(1)) run_q <= 1'b0;
            end
        end
    end

    // Status and read mux.
    always_comb begin
        busy    = pend_q || run_q;
        clr_en  = run_q;
        clr_idx = cur_q;
        cfg_rdata = '0;
        if (cfg_addr == OFS_START) begin
            cfg_rdata = start_q;
        end else if (cfg_addr == OFS_CTRL) begin
            cfg_rdata[COUNT_W-1:0] = count_q;
            cfg_rdata[31]          = busy;
        end
    end

endmodule

// File: rtl/icache_ctrl.sv
// Fetch controller: hit detection, miss sequencing and fill writes.
// Assumes the requester holds fetch_req and fetch_addr until fetch_valid,
// and that memory returns the line exactly MEM_LAT cycles after mem_rd_en.
// The policy is sampled when a miss starts and holds for that fill.
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int OFF_W     = 3,
    parameter int IDX_W     = 10,
    parameter int TAG_W     = 7,
    parameter int WORD_W    = 32,
    parameter int LINE_BITS = 256,
    parameter int MEM_LAT   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              mode,
    input  logic                    fetch_req,
    input  logic [ADDR_W-1:0]       fetch_addr,
    output logic                    fetch_valid,
    output logic                    fetch_stall,
    output logic [WORD_W-1:0]       fetch_data,
    output logic                    mem_rd_en,
    output logic [ADDR_W-OFF_W-1:0] mem_line_addr,
    input  logic [LINE_BITS-1:0]    mem_rd_data,
    input  logic                    inv_busy,
    output logic                    idle,
    input  logic                    rd_valid,
    input  logic [TAG_W-1:0]        rd_tag,
    input  logic [LINE_BITS-1:0]    rd_line,
    output logic                    wr_en,
    output logic [IDX_W-1:0]        wr_idx,
    output logic [TAG_W-1:0]        wr_tag,
    output logic [LINE_BITS-1:0]    wr_line
);

    localparam int CNT_W = $clog2(MEM_LAT + 1);

    logic              fill_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] miss_addr_q;
    logic              alloc_q;

    policy_e            pol;
    logic               hit;
    logic               serve_hit;
    logic               start_miss;
    logic               deliver;
    logic [OFF_W-1:0]   sel_off;
    logic [LINE_BITS-1:0] sel_line;

    // Hit test, miss launch and delivery selection.
    always_comb begin
        pol        = decode_mode(mode);
        hit        = rd_valid && (rd_tag == fetch_addr[ADDR_W-1 -: TAG_W])
                     && (pol != POL_BYPASS);
        serve_hit  = !fill_q && fetch_req && !inv_busy && hit;
        start_miss = !fill_q && fetch_req && !inv_busy && !hit;
        deliver    = fill_q && (cnt_q == CNT_W'(MEM_LAT));
        sel_off    = deliver ? miss_addr_q[OFF_W-1:0] : fetch_addr[OFF_W-1:0];
        sel_line   = deliver ? mem_rd_data : rd_line;
        fetch_valid = serve_hit || deliver;
        fetch_stall = fetch_req && !fetch_valid;
        fetch_data  = sel_line[int'(sel_off)*WORD_W +: WORD_W];
        mem_rd_en     = start_miss;
        mem_line_addr = fetch_addr[ADDR_W-1:OFF_W];
        wr_en   = deliver && alloc_q;
        wr_idx  = miss_addr_q[OFF_W +: IDX_W];
        wr_tag  = miss_addr_q[ADDR_W-1 -: TAG_W];
        wr_line = mem_rd_data;
        idle    = !fill_q;
    end

    // Miss sequencer: counts memory latency, ends on delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q      <= 1'b0;
            cnt_q       <= '0;
            miss_addr_q <= '0;
            alloc_q     <= 1'b0;
        end else if (start_miss) begin
            fill_q      <= 1'b1;
            cnt_q       <= CNT_W'(1);
            miss_addr_q <= fetch_addr;
            alloc_q     <= (pol == POL_ALLOC);
        end else if (deliver) begin
            fill_q <= 1'b0;
        end else if (fill_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/fetch_icache.sv
// Top of the direct-mapped instruction cache with allocate, freeze and
// bypass policies and register-driven range invalidation.
// Assumes a fixed-latency backing memory and a requester that holds its
// request until served. CACHE_BYTES / (LINE_BITS/8) must be a power of two.
module fetch_icache #(
    parameter int CACHE_BYTES = 32768,
    parameter int LINE_BITS   = 256,
    parameter int WORD_W      = 32,
    parameter int ADDR_W      = 20,
    parameter int MEM_LAT     = 2,
    parameter int COUNT_W     = 24,
    localparam int NUM_LINES  = CACHE_BYTES / (LINE_BITS / 8),
    localparam int OFF_W      = $clog2(LINE_BITS / WORD_W),
    localparam int IDX_W      = $clog2(NUM_LINES),
    localparam int TAG_W      = ADDR_W - IDX_W - OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              mode,
    input  logic                    fetch_req,
    input  logic [ADDR_W-1:0]       fetch_addr,
    output logic                    fetch_valid,
    output logic                    fetch_stall,
    output logic [WORD_W-1:0]       fetch_data,
    output logic                    mem_rd_en,
    output logic [ADDR_W-OFF_W-1:0] mem_line_addr,
    input  logic [LINE_BITS-1:0]    mem_rd_data,
    input  logic                    cfg_we,
    input  logic [2:0]              cfg_addr,
    input  logic [31:0]             cfg_wdata,
    output logic [31:0]             cfg_rdata,
    output logic                    inv_busy
);

    logic                 rd_valid;
    logic [TAG_W-1:0]     rd_tag;
    logic [LINE_BITS-1:0] rd_line;
    logic                 wr_en;
    logic [IDX_W-1:0]     wr_idx;
    logic [TAG_W-1:0]     wr_tag;
    logic [LINE_BITS-1:0] wr_line;
    logic                 clr_en;
    logic [IDX_W-1:0]     clr_idx;
    logic                 ctrl_idle;

    icache_store #(
        .NUM_LINES(NUM_LINES), .IDX_W(IDX_W),
        .TAG_W(TAG_W), .LINE_BITS(LINE_BITS)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(fetch_addr[OFF_W +: IDX_W]),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_line(rd_line),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_line(wr_line),
        .clr_en(clr_en), .clr_idx(clr_idx)
    );

    icache_ctrl #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
        .WORD_W(WORD_W), .LINE_BITS(LINE_BITS), .MEM_LAT(MEM_LAT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_valid(fetch_valid), .fetch_stall(fetch_stall),
        .fetch_data(fetch_data),
        .mem_rd_en(mem_rd_en), .mem_line_addr(mem_line_addr),
        .mem_rd_data(mem_rd_data),
        .inv_busy(inv_busy), .idle(ctrl_idle),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_line(rd_line),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_line(wr_line)
    );

    icache_inv_engine #(
        .NUM_LINES(NUM_LINES), .IDX_W(IDX_W),
        .OFF_W(OFF_W), .COUNT_W(COUNT_W)
    ) u_inv (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .allow(ctrl_idle), .busy(inv_busy),
        .clr_en(clr_en), .clr_idx(clr_idx)
    );

endmodule

// File: rtl/fetch_icache_checker.sv
// Protocol and policy properties for fetch_icache, attached by bind.
// Tracks cycles since the last memory read to check delivery timing.
module fetch_icache_checker #(
    parameter int MEM_LAT = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       fetch_valid,
    input logic       mem_rd_en,
    input logic       inv_busy
);

    logic [7:0] since_rd_q;

    // Cycles since the last mem_rd_en, saturating; all-ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rd_q <= 8'hFF;
        else if (mem_rd_en)         since_rd_q <= 8'd1;
        else if (since_rd_q != 8'hFF) since_rd_q <= since_rd_q + 8'd1;
    end

    assert_rd_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    assert_no_early_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !fetch_valid);

    assert_bypass_from_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && mode == 3'b100) |-> (since_rd_q == 8'(MEM_LAT)));

    assert_reserved_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && (mode == 3'b001 || mode[2:1] == 2'b11 || mode == 3'b101))
        |-> (since_rd_q == 8'(MEM_LAT)));

    assert_stall_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inv_busy |-> (!fetch_valid && !mem_rd_en));

endmodule

bind fetch_icache fetch_icache_checker #(.MEM_LAT(MEM_LAT)) u_checker (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fetch_valid(fetch_valid),
    .mem_rd_en(mem_rd_en), .inv_busy(inv_busy)
);

// File: tb/fetch_icache_test.sv
// Self-checking bench: directed corners plus seeded random traffic,
// checked against a bench model of valid bits and tags.
module fetch_icache_test;

    localparam int ADDR_W    = 20;
    localparam int LINE_BITS = 256;
    localparam int MEM_LAT   = 2;
    localparam int NUM_LINES = 1024;
    localparam int OFF_W     = 3;
    localparam int IDX_W     = 10;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [2:0]              mode = 3'b000;
    logic                    fetch_req = 1'b0;
    logic [ADDR_W-1:0]       fetch_addr = '0;
    logic                    fetch_valid, fetch_stall;
    logic [31:0]             fetch_data;
    logic                    mem_rd_en;
    logic [ADDR_W-OFF_W-1:0] mem_line_addr;
    logic [LINE_BITS-1:0]    mem_rd_data;
    logic                    cfg_we = 1'b0;
    logic [2:0]              cfg_addr = 3'h0;
    logic [31:0]             cfg_wdata = '0;
    logic [31:0]             cfg_rdata;
    logic                    inv_busy;

    int nchecks = 0;
    int nerr    = 0;
    bit done    = 1'b0;

    bit model_v [NUM_LINES];
    int model_t [NUM_LINES];

    always #4 clk = ~clk;  // 125 MHz

    fetch_icache uut (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_valid(fetch_valid), .fetch_stall(fetch_stall),
        .fetch_data(fetch_data),
        .mem_rd_en(mem_rd_en), .mem_line_addr(mem_line_addr),
        .mem_rd_data(mem_rd_data),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .inv_busy(inv_busy)
    );

    function automatic logic [31:0] word_val(input logic [ADDR_W-1:0] a);
        return (32'(a) * 32'h9E37_79B1) ^ 32'hC3A5_0F0F;
    endfunction

    function automatic logic [LINE_BITS-1:0] line_val(input logic [ADDR_W-OFF_W-1:0] la);
        logic [LINE_BITS-1:0] l;
        for (int w = 0; w < 8; w++) l[w*32 +: 32] = word_val({la, 3'(w)});
        return l;
    endfunction

    // 0 allocate, 1 freeze, 2 bypass (R4, R5, R6, R7 encodings)
    function automatic int policy_of(input logic [2:0] m);
        if (m == 3'b000 || m == 3'b010) return 0;
        if (m == 3'b011) return 1;
        return 2;
    endfunction

    // Backing memory: fixed latency pipeline of line addresses.
    logic [ADDR_W-OFF_W-1:0] mem_pipe [MEM_LAT];
    always @(posedge clk) begin
        mem_pipe[0] <= mem_line_addr;
        for (int i = 1; i < MEM_LAT; i++) mem_pipe[i] <= mem_pipe[i-1];
    end
    assign mem_rd_data = line_val(mem_pipe[MEM_LAT-1]);

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        mode = m;
    endtask

    task automatic do_fetch(input logic [ADDR_W-1:0] a, input string rq);
        int idx, tg, lat, pol;
        bit hit;
        idx = int'(a[OFF_W +: IDX_W]);
        tg  = int'(a[ADDR_W-1:OFF_W+IDX_W]);
        pol = policy_of(mode);
        hit = (pol != 2) && model_v[idx] && (model_t[idx] == tg);
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = a;
        #1;
        if (!hit)
            check(mem_rd_en === 1'b1 && mem_line_addr === a[ADDR_W-1:OFF_W],
                  "R3", "miss line read", longint'(mem_line_addr),
                  longint'(a[ADDR_W-1:OFF_W]));
        lat = 0;
        while (fetch_valid !== 1'b1 && lat < 20) begin
            @(negedge clk);
            #1;
            lat++;
        end
        check(lat == (hit ? 0 : MEM_LAT), hit ? "R2" : rq, "fetch latency",
              longint'(lat), longint'(hit ? 0 : MEM_LAT));
        check(fetch_data === word_val(a), hit ? "R2" : "R3", "fetch data",
              longint'(fetch_data), longint'(word_val(a)));
        if (!hit && pol == 0) begin
            model_v[idx] = 1'b1;
            model_t[idx] = tg;
        end
        @(posedge clk);
        #1;
        fetch_req = 1'b0;
    endtask

    task automatic do_inv(input int unsigned st, input int unsigned cnt);
        longint first, last, n;
        int busy_cyc;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'h0; cfg_wdata = st;
        @(negedge clk);
        cfg_addr = 3'h4; cfg_wdata = cnt;
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = 3'h0;
        #1;
        check(cfg_rdata === st, "R8", "start readback",
              longint'(cfg_rdata), longint'(st));
        cfg_addr = 3'h4;
        #1;
        check(cfg_rdata[23:0] === cnt[23:0], "R8", "count readback",
              longint'(cfg_rdata[23:0]), longint'(cnt[23:0]));
        busy_cyc = 0;
        while (cfg_rdata[31] === 1'b1 && busy_cyc < 3000) begin
            @(negedge clk);
            #1;
            busy_cyc++;
        end
        n = 0;
        if (cnt != 0) begin
            first = longint'(st) >> OFF_W;
            last  = (longint'(st) + longint'(cnt) - 1) >> OFF_W;
            n     = last - first + 1;
            if (n > NUM_LINES) n = NUM_LINES;
            for (longint i = 0; i < n; i++) model_v[(first + i) % NUM_LINES] = 1'b0;
        end
        check(busy_cyc == ((n == 0) ? 0 : n + 1), "R9", "busy duration",
              longint'(busy_cyc), (n == 0) ? 0 : n + 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchecks++;
            $display("FAIL watchdog expired (all requirements): actual hang expected finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end

    initial begin : stim
        int r;
        logic [ADDR_W-1:0] a;
        void'($urandom(32'd2024));
        for (int i = 0; i < NUM_LINES; i++) begin model_v[i] = 1'b0; model_t[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cfg_addr = 3'h4;
        #1;
        check(cfg_rdata === 32'h0, "R1", "reset status", longint'(cfg_rdata), 0);
        check(fetch_valid === 1'b0 && inv_busy === 1'b0, "R1", "idle after reset",
              longint'({fetch_valid, inv_busy}), 0);

        // R1/R4: reset code 000 allocates; first fetch misses
        do_fetch(20'h00040, "R1");
        do_fetch(20'h00041, "R4");
        do_fetch(20'h00047, "R4");
        set_mode(3'b010);
        do_fetch(20'h00108, "R4");
        do_fetch(20'h0010F, "R4");
        // R5 freeze: hit served, miss does not allocate
        set_mode(3'b011);
        do_fetch(20'h00043, "R5");
        do_fetch(20'h00200, "R5");
        do_fetch(20'h00201, "R5");
        // R6 bypass: always miss, contents kept
        set_mode(3'b100);
        do_fetch(20'h00040, "R6");
        set_mode(3'b010);
        do_fetch(20'h00042, "R6");
        // R7 reserved codes act as bypass
        set_mode(3'b101); do_fetch(20'h00044, "R7");
        set_mode(3'b110); do_fetch(20'h00045, "R7");
        set_mode(3'b111); do_fetch(20'h00046, "R7");
        set_mode(3'b001); do_fetch(20'h00041, "R7");
        set_mode(3'b010);
        do_fetch(20'h00046, "R7");
        // R4 tag conflict eviction
        do_fetch(20'h02040, "R4");
        do_fetch(20'h00040, "R4");
        // R9 range invalidation: lines 10..13, clear words 84..99 (lines 10..12)
        for (int k = 10; k < 14; k++) do_fetch(ADDR_W'(k * 8), "R4");
        do_inv(32'd84, 32'd16);
        do_fetch(20'h00050, "R9");
        do_fetch(20'h00060, "R9");
        do_fetch(20'h00068, "R9");
        // R9 zero count does nothing
        do_inv(32'd104, 32'd0);
        do_fetch(20'h0006A, "R9");
        // R9 oversize range wraps and caps at all lines
        do_inv(32'h0001_FFF8, 32'd20000);
        do_fetch(20'h00068, "R9");
        // R10 write while busy ignored; R9 stall while busy
        do_fetch(20'h01C20, "R4");
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'h0; cfg_wdata = 32'd0;
        @(negedge clk);
        cfg_addr = 3'h4; cfg_wdata = 32'd6400;
        @(negedge clk);
        cfg_wdata = 32'd5;
        @(negedge clk);
        cfg_we = 1'b0;
        fetch_req = 1'b1; fetch_addr = 20'h01C20;
        #1;
        check(cfg_rdata[23:0] === 24'd6400, "R10", "count after busy write",
              longint'(cfg_rdata[23:0]), 6400);
        check(fetch_valid === 1'b0 && fetch_stall === 1'b1, "R9", "stall while busy",
              longint'({fetch_valid, fetch_stall}), 1);
        @(posedge clk);
        #1;
        fetch_req = 1'b0;
        while (inv_busy === 1'b1) @(negedge clk);
        for (int k = 0; k < 800; k++) model_v[k] = 1'b0;
        do_fetch(20'h01C20, "R9");
        do_fetch(20'h01900, "R10");
        do_fetch(20'h00028, "R9");

        // Seeded random traffic
        for (int it = 0; it < 500; it++) begin
            r = int'($urandom % 16);
            if (r == 0) begin
                set_mode(3'($urandom % 8));
            end else if (r == 1) begin
                do_inv($urandom % 600, $urandom % 48);
            end else begin
                a = ADDR_W'(($urandom % 64) * 8 + ($urandom % 8))
                  | (ADDR_W'($urandom % 3) << 13);
                case (policy_of(mode))
                    0: do_fetch(a, "R4");
                    1: do_fetch(a, "R5");
                    default: do_fetch(a, (mode == 3'b100) ? "R6" : "R7");
                endcase
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

endmodule